// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block decides which of a parameterised set of target processors receive an interrupt message, then turns the message into per-target request strobes according to its delivery mode. Every target presents a static configuration: an 8-bit legacy identifier, a 32-bit extended identifier, a flag that puts it in extended addressing, an 8-bit logical identifier with a flat or cluster model select, and a 32-bit extended logical identifier made of a 16-bit cluster number and 16 member bits.

A message carries a 32-bit destination, a physical/logical select, a 2-bit shorthand, the sender's target index, a 3-bit delivery mode, an 8-bit vector and the level and trigger bits. It is taken on a valid/ready handshake. One cycle later the block presents the registered recipient mask and a one-cycle pulse on the strobe bus that the mode selects. The per-processor priority logic that consumes the strobes is not part of this block. Lowest-priority arbitration is simplified: the lowest-indexed selected target wins.

Top module: `ipi_dest_router`

## Requirements
- R1: Shorthand 0 uses destination matching, 1 selects only the target whose index equals `msg_src`, 2 selects every target, and 3 selects every target except `msg_src`.
- R2: In physical mode (`msg_logical`=0), a destination of all ones selects every target. Otherwise an extended-mode target is selected when the whole destination equals its extended ID, and a legacy target when destination bits 7:0 equal its 8-bit ID or the whole destination equals 0x000000FF.
- R3: In logical mode, an extended-mode target is selected when destination bits 31:16 equal bits 31:16 of its extended logical ID and destination bits 15:0 share a set bit with its bits 15:0. A destination of all ones selects every extended-mode target.
- R4: In logical mode, a legacy target with model select 0 (flat) is selected when destination bits 7:0 share a set bit with its logical ID.
- R5: In logical mode, a legacy target with model select 1 (cluster) is selected when destination bits 7:4 are 0xF or equal bits 7:4 of its logical ID, and destination bits 3:0 share a set bit with bits 3:0 of its logical ID.
- R6: Delivery mode 0 (fixed) pulses `fixed_stb` at every selected target, and `out_trig` carries the message trigger bit.
- R7: Delivery mode 1 (lowest priority) pulses `fixed_stb` only at the lowest-indexed selected target, and at none when nothing is selected.
- R8: Delivery modes 2 (SMI), 4 (NMI) and 5 (INIT) pulse `smi_stb`, `nmi_stb` and `init_stb` respectively at every selected target.
- R9: An INIT message with level bit 0 and trigger bit 1 pulses no strobe.
- R10: Delivery mode 6 (startup) pulses `start_stb` at every selected target; `out_vector` carries the message vector.
- R11: Delivery modes 3 and 7 pulse no strobe; the recipient mask is still produced, and an all-zero mask is a legal result.
- R12: A message is accepted in a cycle where `msg_valid` and `msg_ready` are both high; the mask and strobes appear after the next rising edge, strobes last one cycle, and the mask holds until the next accepted message. During reset `msg_ready` is low and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Block can take a message |
| msg_dest | input | 32 | Destination field |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_short | input | 2 | Shorthand select |
| msg_src | input | clog2(N_TGT) | Sender's target index |
| msg_dmode | input | 3 | Delivery mode |
| msg_vector | input | 8 | Interrupt vector |
| msg_level | input | 1 | Level bit |
| msg_trig | input | 1 | Trigger bit (1 = level) |
| cfg_phys_id | input | 8*N_TGT | Legacy ID per target |
| cfg_ext_id | input | 32*N_TGT | Extended ID per target |
| cfg_ext_mode | input | N_TGT | Extended addressing flag per target |
| cfg_log_id | input | 8*N_TGT | Legacy logical ID per target |
| cfg_cluster | input | N_TGT | 1 = cluster model, 0 = flat |
| cfg_ext_log_id | input | 32*N_TGT | Extended logical ID per target |
| rcpt_mask | output | N_TGT | Registered recipient mask |
| fixed_stb | output | N_TGT | Fixed request pulses |
| smi_stb | output | N_TGT | SMI pulses |
| nmi_stb | output | N_TGT | NMI pulses |
| init_stb | output | N_TGT | INIT pulses |
| start_stb | output | N_TGT | Startup pulses |
| out_vector | output | 8 | Vector of the last accepted message |
| out_trig | output | 1 | Trigger bit of the last accepted message |

## Verification
A wrong match term for one addressing model shows up as a single wrong bit in `rcpt_mask` one cycle after the message is accepted, so each model is driven with destinations that hit some targets and miss others in the same message. A wrong mode decode shows as a pulse on the wrong strobe bus in that same cycle, and a stuck strobe register shows one cycle later, when no message was accepted and the bus should be quiet. Lowest-priority picking is exposed by masks whose lowest set bit is not bit 0.

// File: rtl/ipi_dest_pkg.sv
// Shared types for the interrupt destination mask generator.
// Assumes: delivery mode and shorthand encodings are fixed by the message format.
package ipi_dest_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD3  = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSVD7  = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_MATCH  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_e;

    localparam logic [31:0] DEST_ALL    = 32'hFFFF_FFFF;
    localparam logic [31:0] DEST_LEGACY = 32'h0000_00FF;
    localparam logic [3:0]  CLUSTER_ANY = 4'hF;

    typedef struct packed {
        logic [7:0]  phys_id;
        logic [31:0] ext_id;
        logic        ext_mode;
        logic [7:0]  log_id;
        logic        cluster;
        logic [31:0] ext_log_id;
    } tgt_cfg_t;

endpackage

// File: rtl/ipi_tgt_match.sv
// Destination match for one target: decides whether a message addressed
// by destination and mode selects this target. Pure combinational.
// Assumes: configuration is static while messages flow.
module ipi_tgt_match
    import ipi_dest_pkg::*;
(
    input  tgt_cfg_t    cfg,
    input  logic [31:0] dest,
    input  logic        logical,
    output logic        hit
);

    logic [7:0] dest_lo;
    logic       phys_hit;
    logic       ext_log_hit;
    logic       flat_hit;
    logic       clus_hit;

    assign dest_lo = dest[7:0];

    // Physical match: global broadcast, extended full compare, legacy low byte or legacy broadcast
    always_comb begin
        if (dest == DEST_ALL) begin
            phys_hit = 1'b1;
        end else if (cfg.ext_mode) begin
            phys_hit = (dest == cfg.ext_id);
        end else begin
            phys_hit = (dest_lo == cfg.phys_id) || (dest == DEST_LEGACY);
        end
    end

    // Extended logical match: same cluster number and overlapping member bits, or all-ones
    assign ext_log_hit = (dest == DEST_ALL) ||
                         ((dest[31:16] == cfg.ext_log_id[31:16]) &&
                          (|(dest[15:0] & cfg.ext_log_id[15:0])));

    // Legacy flat model: any shared bit
    assign flat_hit = |(dest_lo & cfg.log_id);

    // Legacy cluster model: cluster nibble equal or wildcard, plus shared member bit
    assign clus_hit = ((dest_lo[7:4] == CLUSTER_ANY) || (dest_lo[7:4] == cfg.log_id[7:4])) &&
                      (|(dest_lo[3:0] & cfg.log_id[3:0]));

    // Final selection by addressing mode and target model
    always_comb begin
        if (!logical) begin
            hit = phys_hit;
        end else if (cfg.ext_mode) begin
            hit = ext_log_hit;
        end else if (cfg.cluster) begin
            hit = clus_hit;
        end else begin
            hit = flat_hit;
        end
    end

endmodule

// File: rtl/ipi_mask_build.sv
// Applies the shorthand to the per-target match vector and yields the
// selection mask. Pure combinational.
// Assumes: src is a valid target index.
module ipi_mask_build
    import ipi_dest_pkg::*;
#(
    parameter int N_TGT = 8,
    localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic [N_TGT-1:0] hits,
    input  logic [1:0]       short_sel,
    input  logic [IDXW-1:0]  src,
    output logic [N_TGT-1:0] sel
);

    for (genvar i = 0; i < N_TGT; i++) begin : g_bit
        logic is_src;
        assign is_src = (src == IDXW'(i));

        // Per-target selection under the four shorthand codes
        always_comb begin
            unique case (short_e'(short_sel))
                SH_MATCH:  sel[i] = hits[i];
                SH_SELF:   sel[i] = is_src;
                SH_ALL:    sel[i] = 1'b1;
                SH_OTHERS: sel[i] = !is_src;
                default:   sel[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_dispatch.sv
// Registers the selection mask and raises one-cycle strobes on the bus the
// delivery mode names; lowest priority keeps only the lowest-indexed target.
// Assumes: accept is high for exactly the cycles in which a message is taken.
module ipi_dispatch
    import ipi_dest_pkg::*;
#(
    parameter int N_TGT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [N_TGT-1:0] sel,
    input  logic [2:0]       dmode,
    input  logic [7:0]       vector,
    input  logic             level,
    input  logic             trig,
    output logic [N_TGT-1:0] mask_q,
    output logic [N_TGT-1:0] fixed_q,
    output logic [N_TGT-1:0] smi_q,
    output logic [N_TGT-1:0] nmi_q,
    output logic [N_TGT-1:0] init_q,
    output logic [N_TGT-1:0] start_q,
    output logic [7:0]       vector_q,
    output logic             trig_q
);

    logic [N_TGT-1:0] lowest;
    logic             init_deassert;

    // Isolate the lowest set bit of the selection
    assign lowest        = sel & (~sel + N_TGT'(1));
    assign init_deassert = !level && trig;

    // Capture mask and payload on accept; strobes live for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            fixed_q  <= '0;
            smi_q    <= '0;
            nmi_q    <= '0;
            init_q   <= '0;
            start_q  <= '0;
            vector_q <= '0;
            trig_q   <= 1'b0;
        end else begin
            fixed_q <= '0;
            smi_q   <= '0;
            nmi_q   <= '0;
            init_q  <= '0;
            start_q <= '0;
            if (accept) begin
                mask_q   <= sel;
                vector_q <= vector;
                trig_q   <= trig;
                case (dmode_e'(dmode))
                    DM_FIXED:  fixed_q <= sel;
                    DM_LOWEST: fixed_q <= lowest;
                    DM_SMI:    smi_q   <= sel;
                    DM_NMI:    nmi_q   <= sel;
                    DM_INIT:   init_q  <= init_deassert ? '0 : sel;
                    DM_START:  start_q <= sel;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ipi_dest_router.sv
// Top of the interrupt destination mask generator: unpacks per-target
// configuration, matches every target in parallel, applies the shorthand
// and dispatches by delivery mode one cycle after the handshake.
// Assumes: configuration inputs are static; N_TGT >= 2.
module ipi_dest_router
    import ipi_dest_pkg::*;
#(
    parameter int N_TGT = 8,
    localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    output logic               msg_ready,
    input  logic [31:0]        msg_dest,
    input  logic               msg_logical,
    input  logic [1:0]         msg_short,
    input  logic [IDXW-1:0]    msg_src,
    input  logic [2:0]         msg_dmode,
    input  logic [7:0]         msg_vector,
    input  logic               msg_level,
    input  logic               msg_trig,
    input  logic [8*N_TGT-1:0] cfg_phys_id,
    input  logic [32*N_TGT-1:0] cfg_ext_id,
    input  logic [N_TGT-1:0]   cfg_ext_mode,
    input  logic [8*N_TGT-1:0] cfg_log_id,
    input  logic [N_TGT-1:0]   cfg_cluster,
    input  logic [32*N_TGT-1:0] cfg_ext_log_id,
    output logic [N_TGT-1:0]   rcpt_mask,
    output logic [N_TGT-1:0]   fixed_stb,
    output logic [N_TGT-1:0]   smi_stb,
    output logic [N_TGT-1:0]   nmi_stb,
    output logic [N_TGT-1:0]   init_stb,
    output logic [N_TGT-1:0]   start_stb,
    output logic [7:0]         out_vector,
    output logic               out_trig
);

    logic             ready_q;
    logic             accept;
    logic [N_TGT-1:0] hits;
    logic [N_TGT-1:0] sel;

    // Ready rises on the first cycle after reset and stays high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign msg_ready = ready_q;
    assign accept    = msg_valid && ready_q;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        tgt_cfg_t cfg;
        assign cfg.phys_id    = cfg_phys_id[i*8 +: 8];
        assign cfg.ext_id     = cfg_ext_id[i*32 +: 32];
        assign cfg.ext_mode   = cfg_ext_mode[i];
        assign cfg.log_id     = cfg_log_id[i*8 +: 8];
        assign cfg.cluster    = cfg_cluster[i];
        assign cfg.ext_log_id = cfg_ext_log_id[i*32 +: 32];

        ipi_tgt_match u_match (
            .cfg     (cfg),
            .dest    (msg_dest),
            .logical (msg_logical),
            .hit     (hits[i])
        );
    end

    ipi_mask_build #(.N_TGT(N_TGT)) u_mask (
        .hits      (hits),
        .short_sel (msg_short),
        .src       (msg_src),
        .sel       (sel)
    );

    ipi_dispatch #(.N_TGT(N_TGT)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .sel      (sel),
        .dmode    (msg_dmode),
        .vector   (msg_vector),
        .level    (msg_level),
        .trig     (msg_trig),
        .mask_q   (rcpt_mask),
        .fixed_q  (fixed_stb),
        .smi_q    (smi_stb),
        .nmi_q    (nmi_stb),
        .init_q   (init_stb),
        .start_q  (start_stb),
        .vector_q (out_vector),
        .trig_q   (out_trig)
    );

endmodule

// File: rtl/ipi_dest_checker.sv
// Temporal checks on the router's ports; bound into every instance.
// Assumes: the same N_TGT as the bound instance.
module ipi_dest_checker #(
    parameter int N_TGT = 8,
    localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [1:0]       msg_short,
    input logic [IDXW-1:0]  msg_src,
    input logic [2:0]       msg_dmode,
    input logic             msg_level,
    input logic             msg_trig,
    input logic [N_TGT-1:0] rcpt_mask,
    input logic [N_TGT-1:0] fixed_stb,
    input logic [N_TGT-1:0] smi_stb,
    input logic [N_TGT-1:0] nmi_stb,
    input logic [N_TGT-1:0] init_stb,
    input logic [N_TGT-1:0] start_stb
);

    logic acc;
    logic [N_TGT-1:0] any_stb;
    assign acc     = msg_valid && msg_ready;
    assign any_stb = fixed_stb | smi_stb | nmi_stb | init_stb | start_stb;

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (any_stb == '0)); // R12

    AST_STROBE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((any_stb & ~rcpt_mask) == '0)); // R12

    AST_ONE_BUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|fixed_stb, |smi_stb, |nmi_stb, |init_stb, |start_stb})); // R11

    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && msg_dmode == 3'd1) |=> ($onehot0(fixed_stb) &&
                                         ((rcpt_mask != '0) == (fixed_stb != '0)))); // R7

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && msg_short == 2'd2) |=> (&rcpt_mask)); // R1

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && msg_short == 2'd1) |=> (rcpt_mask == (N_TGT'(1) << $past(msg_src)))); // R1

    AST_INIT_DEASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && msg_dmode == 3'd5 && !msg_level && msg_trig) |=> (init_stb == '0)); // R9

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (msg_dmode == 3'd3 || msg_dmode == 3'd7)) |=> (any_stb == '0)); // R11

endmodule

bind ipi_dest_router ipi_dest_checker #(.N_TGT(N_TGT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_short (msg_short),
    .msg_src   (msg_src),
    .msg_dmode (msg_dmode),
    .msg_level (msg_level),
    .msg_trig  (msg_trig),
    .rcpt_mask (rcpt_mask),
    .fixed_stb (fixed_stb),
    .smi_stb   (smi_stb),
    .nmi_stb   (nmi_stb),
    .init_stb  (init_stb),
    .start_stb (start_stb)
);

// File: tb/ipi_dest_router_bench.sv
`timescale 1ns/1ps
module ipi_dest_router_bench;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           msg_valid = 1'b0;
    logic           msg_ready;
    logic [31:0]    msg_dest = '0;
    logic           msg_logical = 1'b0;
    logic [1:0]     msg_short = '0;
    logic [2:0]     msg_src = '0;
    logic [2:0]     msg_dmode = '0;
    logic [7:0]     msg_vector = '0;
    logic           msg_level = 1'b0;
    logic           msg_trig = 1'b0;
    logic [8*N-1:0]  cfg_phys_id;
    logic [32*N-1:0] cfg_ext_id;
    logic [N-1:0]    cfg_ext_mode;
    logic [8*N-1:0]  cfg_log_id;
    logic [N-1:0]    cfg_cluster;
    logic [32*N-1:0] cfg_ext_log_id;
    logic [N-1:0]   rcpt_mask, fixed_stb, smi_stb, nmi_stb, init_stb, start_stb;
    logic [7:0]     out_vector;
    logic           out_trig;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ipi_dest_router #(.N_TGT(N)) u_ipi_dest_router (.*);

    // Static target configuration: 0..2 flat, 3..5 cluster, 6..7 extended
    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_phys_id[i*8 +: 8]     = 8'h10 + 8'(i);
            cfg_ext_id[i*32 +: 32]    = 32'h100 + 32'(i);
            cfg_ext_mode[i]           = (i >= 6);
            cfg_cluster[i]            = (i >= 3 && i <= 5);
            cfg_ext_log_id[i*32 +: 32] = 32'h0005_0000 | (32'h1 << (i - 6));
        end
        cfg_log_id = {8'hFF, 8'hFF, 8'h31, 8'h22, 8'h21, 8'h04, 8'h02, 8'h01};
    end

    typedef struct packed {
        logic [31:0] dest;
        logic        lg;
        logic [1:0]  sh;
        logic [2:0]  src;
        logic [2:0]  dm;
        logic [7:0]  vec;
        logic        lvl;
        logic        trg;
        logic [7:0]  m;
        logic [7:0]  fx;
        logic [7:0]  sm;
        logic [7:0]  nm;
        logic [7:0]  it;
        logic [7:0]  st;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{32'h12,        1'b0, 2'd0, 3'd0, 3'd0, 8'h41, 1'b1, 1'b0, 8'h04, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'd2},  // R2 legacy id
        '{32'h107,       1'b0, 2'd0, 3'd0, 3'd0, 8'h42, 1'b1, 1'b1, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'd6},  // R6 R2 extended id
        '{32'h16,        1'b0, 2'd0, 3'd0, 3'd0, 8'h43, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd2},  // R2 ext target ignores legacy id
        '{32'hFF,        1'b0, 2'd0, 3'd0, 3'd4, 8'h44, 1'b1, 1'b0, 8'h3F, 8'h00, 8'h00, 8'h3F, 8'h00, 8'h00, 8'd2},  // R2 legacy broadcast, NMI
        '{32'hFFFFFFFF,  1'b0, 2'd0, 3'd0, 3'd2, 8'h45, 1'b1, 1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd8},  // R8 SMI, global
        '{32'h03,        1'b1, 2'd0, 3'd0, 3'd0, 8'h46, 1'b1, 1'b0, 8'h03, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'd4},  // R4 flat
        '{32'h23,        1'b1, 2'd0, 3'd0, 3'd0, 8'h47, 1'b1, 1'b0, 8'h1B, 8'h1B, 8'h00, 8'h00, 8'h00, 8'h00, 8'd5},  // R5 cluster 2
        '{32'hF1,        1'b1, 2'd0, 3'd0, 3'd5, 8'h48, 1'b1, 1'b0, 8'h29, 8'h00, 8'h00, 8'h00, 8'h29, 8'h00, 8'd5},  // R5 wildcard cluster, INIT
        '{32'h0005_0003, 1'b1, 2'd0, 3'd0, 3'd1, 8'h49, 1'b1, 1'b0, 8'hC3, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'd3},  // R3 R7
        '{32'h0005_0002, 1'b1, 2'd0, 3'd0, 3'd1, 8'h4A, 1'b1, 1'b0, 8'h82, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'd7},  // R7 lowest not bit 0
        '{32'h0006_0001, 1'b1, 2'd0, 3'd0, 3'd0, 8'h4B, 1'b1, 1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'd3},  // R3 cluster number mismatch
        '{32'hFFFFFFFF,  1'b1, 2'd0, 3'd0, 3'd6, 8'h9A, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'd10}, // R10 startup, R3 all-ones
        '{32'h0,         1'b0, 2'd1, 3'd5, 3'd0, 8'h4C, 1'b1, 1'b0, 8'h20, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'd1},  // R1 self
        '{32'h0,         1'b0, 2'd2, 3'd0, 3'd4, 8'h4D, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'd1},  // R1 all
        '{32'h0,         1'b0, 2'd3, 3'd2, 3'd0, 8'h4E, 1'b1, 1'b0, 8'hFB, 8'hFB, 8'h00, 8'h00, 8'h00, 8'h00, 8'd1},  // R1 all but sender
        '{32'h0,         1'b0, 2'd2, 3'd0, 3'd5, 8'h4F, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd9},  // R9 INIT de-assert
        '{32'h0,         1'b0, 2'd2, 3'd0, 3'd3, 8'h50, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd11}, // R11 mode 3
        '{32'h10,        1'b0, 2'd0, 3'd0, 3'd7, 8'h51, 1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd11}, // R11 mode 7
        '{32'h55,        1'b0, 2'd0, 3'd0, 3'd1, 8'h52, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd11}  // R11 R7 empty mask
    };

    task automatic chk(input string what, input int req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        msg_valid   = 1'b1;
        msg_dest    = v.dest;
        msg_logical = v.lg;
        msg_short   = v.sh;
        msg_src     = v.src;
        msg_dmode   = v.dm;
        msg_vector  = v.vec;
        msg_level   = v.lvl;
        msg_trig    = v.trg;
    endtask

    task automatic check_vec(input vec_t v);
        chk("mask",   int'(v.req), 32'(rcpt_mask), 32'(v.m));
        chk("fixed",  int'(v.req), 32'(fixed_stb), 32'(v.fx));
        chk("smi",    int'(v.req), 32'(smi_stb),   32'(v.sm));
        chk("nmi",    int'(v.req), 32'(nmi_stb),   32'(v.nm));
        chk("init",   int'(v.req), 32'(init_stb),  32'(v.it));
        chk("start",  int'(v.req), 32'(start_stb), 32'(v.st));
        chk("vector", int'(v.req), 32'(out_vector), 32'(v.vec));
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog expired: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("ready in reset", 12, 32'(msg_ready), 32'h0);
        chk("mask in reset",  12, 32'(rcpt_mask), 32'h0);
        chk("strobes in reset", 12, 32'(fixed_stb | smi_stb | nmi_stb | init_stb | start_stb), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("ready after reset", 12, 32'(msg_ready), 32'h1);

        // Table walk: drive at a falling edge, result visible after the next rising edge
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k]);
            @(negedge clk);
            msg_valid = 1'b0;
            check_vec(TBL[k]);
        end

        // R6: trigger bit carried with a fixed message
        drive(TBL[1]);
        @(negedge clk);
        msg_valid = 1'b0;
        chk("trig out", 6, 32'(out_trig), 32'h1);

        // R12: strobes drop after one cycle, mask holds while idle
        @(negedge clk);
        chk("strobe pulse width", 12, 32'(fixed_stb), 32'h0);
        chk("mask held", 12, 32'(rcpt_mask), 32'h80);
        msg_dest = 32'h11;
        @(negedge clk);
        chk("no accept without valid", 12, 32'(rcpt_mask), 32'h80);

        // R12: back-to-back messages, each visible in its own cycle
        drive(TBL[0]);
        @(negedge clk);
        check_vec(TBL[0]);
        drive(TBL[13]);
        @(negedge clk);
        msg_valid = 1'b0;
        check_vec(TBL[13]);

        // R12: reset mid-stream clears outputs and ready
        drive(TBL[4]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("mask cleared by reset", 12, 32'(rcpt_mask), 32'h0);
        chk("smi cleared by reset", 12, 32'(smi_stb), 32'h0);
        chk("ready low in reset", 12, 32'(msg_ready), 32'h0);
        msg_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule